// File: doc/BRIEF.md
# Ping-Pong Bulk-Out Receive Endpoint

This block is the receive side of a bulk-out pipe. It holds two packet buffers and uses them in turn. The packet layer signals an OUT token, then sends the payload one byte per valid strobe, then marks the end of the packet with a good or bad status. The block replies with a one-cycle handshake, either ACK or NAK. It answers NAK only when both buffers hold packets that the application has not yet read. If either buffer is free, it stores the packet and acknowledges it once the end marker arrives with good status.

The application sees a single logical FIFO. A full flag and a one-cycle interrupt pulse announce a new packet. The byte count and the current data byte come from the buffer that is next in line to be read. A pop strobe steps the read pointer through the bytes. A read-complete strobe releases the buffer that was just read and moves on to the other buffer. Packets therefore reach the application in the order they arrived. The application never chooses a buffer.

Top module: `bo_ep_pingpong`

## Requirements
- R1: After reset, `ep_full`, `ep_irq` and `hs_valid` are 0, and the first accepted packet goes to buffer 0, with its first byte at read offset 0.
- R2: When an OUT token arrives while at least one buffer is free, the bytes that follow are stored. One cycle after `rx_end` with `rx_good`=1, `hs_valid`=1 and `hs_ack`=1 (1 = ACK, 0 = NAK) for exactly one cycle.
- R3: A committed packet sets `ep_full` and pulses `ep_irq` for one cycle. Both take effect one cycle after the `rx_end` cycle.
- R4: While the first buffer still holds an unread packet, a second packet is accepted and acknowledged without any application action.
- R5: When an OUT token arrives while both buffers hold unread packets, `hs_valid`=1 with `hs_ack`=0 appears one cycle later. The data that follows is discarded, and its end gets no further handshake.
- R6: `rd_size` shows the byte count of the buffer being read, from 0 to 64 inclusive. `rd_data` shows that buffer's byte at the read offset, and each `rd_pop` cycle advances the offset by one.
- R7: `rd_done` releases the buffer being read and moves reading to the next packet in arrival order, starting at offset 0.
- R8: `ep_full` stays 1 after `rd_done` while the other buffer still holds an unread packet. It goes to 0 only when no buffer is full.
- R9: A packet that ends with `rx_good`=0, or that carries more than 64 bytes, is dropped. It gets no handshake, no full flag and no interrupt. The next packet is then stored from offset 0.
- R10: `rd_done` while no buffer is full is ignored. `ep_full` stays 0, and the next packet is read back intact.
- R11: A packet commit and a `rd_done` in the same cycle both take effect. One buffer is released while the other becomes full, so `ep_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | One-cycle OUT token indication |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | 8 | Payload byte |
| rx_end | input | 1 | End-of-packet marker |
| rx_good | input | 1 | Packet status, sampled with `rx_end` (1 = good) |
| hs_valid | output | 1 | Handshake strobe |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK, valid with `hs_valid` |
| ep_full | output | 1 | At least one buffer holds an unread packet |
| ep_irq | output | 1 | One-cycle pulse on each committed packet |
| rd_size | output | 7 | Byte count of the buffer being read |
| rd_data | output | 8 | Byte at the current read offset |
| rd_pop | input | 1 | Advance the read offset |
| rd_done | input | 1 | Read-complete strobe; releases the buffer being read |

## Verification
Two events can land in the same clock edge: the commit of a packet into one buffer and the application's read-complete strobe on the other buffer. The bench fills one buffer, then sends a second packet and raises `rd_done` in the same cycle as that packet's `rx_end`. It then expects ACK, an interrupt pulse and `ep_full` still at 1. The second packet must then read back with its own size and bytes, and a final `rd_done` must clear the flag.

// File: rtl/bo_ep_pkg.sv
package bo_ep_pkg;
   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_TAKE = 2'd1,
      RX_SKIP = 2'd2
   } rx_state_t;
endpackage

// File: rtl/bo_ep_buf.sv
module bo_ep_buf #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/bo_ep_rx.sv
module bo_ep_rx
   import bo_ep_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tok_out,
   input  logic          rx_valid,
   input  logic          rx_end,
   input  logic          rx_good,
   input  logic          both_full,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          commit,
   output logic [CW-1:0] commit_len,
   output logic          hs_valid,
   output logic          hs_ack
);
   localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

   rx_state_t     state;
   logic [CW-1:0] cnt, cnt_nxt;
   logic          ovf, ovf_nxt;
   logic          room;

   assign room    = (cnt != LIMIT);
   assign wr_en   = (state == RX_TAKE) && rx_valid && room;
   assign wr_addr = cnt[AW-1:0];

   always_comb begin
      cnt_nxt = cnt;
      ovf_nxt = ovf;
      if (state == RX_TAKE && rx_valid) begin
         if (room) cnt_nxt = cnt + 1'b1;
         else      ovf_nxt = 1'b1;
      end
   end

   assign commit     = (state == RX_TAKE) && rx_end && rx_good && !ovf_nxt;
   assign commit_len = cnt_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         ovf      <= 1'b0;
         hs_valid <= 1'b0;
         hs_ack   <= 1'b0;
      end else begin
         hs_valid <= 1'b0;
         unique case (state)
            RX_IDLE: if (tok_out) begin
               cnt <= '0;
               ovf <= 1'b0;
               if (both_full) begin
                  hs_valid <= 1'b1;
                  hs_ack   <= 1'b0;
                  state    <= RX_SKIP;
               end else begin
                  state <= RX_TAKE;
               end
            end
            RX_TAKE: begin
               cnt <= cnt_nxt;
               ovf <= ovf_nxt;
               if (rx_end) begin
                  state <= RX_IDLE;
                  cnt   <= '0;
                  ovf   <= 1'b0;
                  if (commit) begin
                     hs_valid <= 1'b1;
                     hs_ack   <= 1'b1;
                  end
               end
            end
            RX_SKIP: if (rx_end) state <= RX_IDLE;
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R5
   nak_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE && tok_out && both_full) |=> (hs_valid && !hs_ack));

   // R9
   no_hs_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_TAKE && rx_end && (!rx_good || ovf_nxt)) |=> !hs_valid);

   // R6
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (commit_len <= LIMIT));
endmodule

// File: rtl/bo_ep_rdptr.sv
module bo_ep_rdptr #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          release_buf,
   output logic [AW-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)           ptr <= '0;
      else if (release_buf) ptr <= '0;
      else if (pop)         ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/bo_ep_pingpong.sv
module bo_ep_pingpong #(
   parameter int DEPTH = 64,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tok_out,
   input  logic                       rx_valid,
   input  logic [DW-1:0]              rx_data,
   input  logic                       rx_end,
   input  logic                       rx_good,
   output logic                       hs_valid,
   output logic                       hs_ack,
   output logic                       ep_full,
   output logic                       ep_irq,
   output logic [$clog2(DEPTH+1)-1:0] rd_size,
   output logic [DW-1:0]              rd_data,
   input  logic                       rd_pop,
   input  logic                       rd_done
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int NBUF = 2;

   if (DEPTH < 2) begin : g_bad_depth
      $error("bo_ep_pingpong: DEPTH must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("bo_ep_pingpong: DW must be at least 1");
   end

   logic [NBUF-1:0] full;
   logic [CW-1:0]   len [NBUF];
   logic            wr_sel, rd_sel;
   logic            wr_en, commit, release_buf;
   logic [AW-1:0]   wr_addr, rd_ptr;
   logic [CW-1:0]   commit_len;
   logic [DW-1:0]   bdat [NBUF];

   bo_ep_rx #(.DEPTH(DEPTH), .DW(DW)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tok_out    (tok_out),
      .rx_valid   (rx_valid),
      .rx_end     (rx_end),
      .rx_good    (rx_good),
      .both_full  (&full),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .commit     (commit),
      .commit_len (commit_len),
      .hs_valid   (hs_valid),
      .hs_ack     (hs_ack)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      bo_ep_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
         .clk     (clk),
         .wr_en   (wr_en && (wr_sel == 1'(g))),
         .wr_addr (wr_addr),
         .wr_data (rx_data),
         .rd_addr (rd_ptr),
         .rd_data (bdat[g])
      );
   end

   assign release_buf = rd_done && full[rd_sel];

   bo_ep_rdptr #(.DEPTH(DEPTH)) u_rdptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .pop         (rd_pop),
      .release_buf (release_buf),
      .ptr         (rd_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= '0;
         wr_sel <= 1'b0;
         rd_sel <= 1'b0;
         ep_irq <= 1'b0;
         for (int i = 0; i < NBUF; i++) len[i] <= '0;
      end else begin
         ep_irq <= commit;
         if (commit) begin
            full[wr_sel] <= 1'b1;
            len[wr_sel]  <= commit_len;
            wr_sel       <= ~wr_sel;
         end
         if (release_buf) begin
            full[rd_sel] <= 1'b0;
            rd_sel       <= ~rd_sel;
         end
      end
   end

   assign ep_full = |full;
   assign rd_size = len[rd_sel];
   assign rd_data = bdat[rd_sel];

   // R2
   commit_to_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !full[wr_sel]);

   // R3
   irq_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (ep_irq && ep_full));

   // R8
   full_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ep_full) |-> $past(rd_done));

   // R10
   idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !ep_full && !commit) |=> (!ep_full && $stable(rd_sel)));
endmodule

// File: tb/bo_ep_pingpong_tb_top.sv
module bo_ep_pingpong_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tok_out = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_good = 1'b0;
   logic [7:0] rx_data = '0;
   logic       hs_valid, hs_ack, ep_full, ep_irq;
   logic [6:0] rd_size;
   logic [7:0] rd_data;
   logic       rd_pop = 1'b0, rd_done = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   bo_ep_pingpong dut_i (
      .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_end(rx_end), .rx_good(rx_good),
      .hs_valid(hs_valid), .hs_ack(hs_ack), .ep_full(ep_full), .ep_irq(ep_irq),
      .rd_size(rd_size), .rd_data(rd_data), .rd_pop(rd_pop), .rd_done(rd_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'(seed + i * 3);
   endfunction

   // Sends one packet; all checks happen on the negedge after each input cycle.
   task automatic send(input int n, input int seed, input bit good,
                       input bit exp_nak, input bit exp_commit,
                       input bit exp_full, input bit done_at_end, input string req);
      tok_out = 1'b1;
      @(negedge clk);
      tok_out = 1'b0;
      chk(hs_valid == exp_nak, {req, " token handshake"}, hs_valid, exp_nak);
      if (exp_nak) chk(hs_ack == 1'b0, {req, " NAK code"}, hs_ack, 0);
      for (int i = 0; i < n; i++) begin
         rx_valid = 1'b1;
         rx_data  = pat(seed, i);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_end   = 1'b1;
      rx_good  = good;
      rd_done  = done_at_end;
      @(negedge clk);
      rx_end  = 1'b0;
      rx_good = 1'b0;
      rd_done = 1'b0;
      chk(hs_valid == exp_commit, {req, " end handshake"}, hs_valid, exp_commit);
      if (exp_commit) chk(hs_ack == 1'b1, {req, " ACK code"}, hs_ack, 1);
      chk(ep_irq == exp_commit, {req, " irq"}, ep_irq, exp_commit);
      chk(ep_full == exp_full, {req, " full"}, ep_full, exp_full);
      @(negedge clk);
      chk(ep_irq == 1'b0, {req, " irq one cycle"}, ep_irq, 0);
      chk(hs_valid == 1'b0, {req, " handshake one cycle"}, hs_valid, 0);
   endtask

   task automatic readout(input int n, input int seed, input bit exp_full_after, input string req);
      chk(rd_size == 7'(n), {req, " size"}, rd_size, n);
      for (int i = 0; i < n; i++) begin
         chk(rd_data == pat(seed, i), {req, " data"}, rd_data, pat(seed, i));
         rd_pop = 1'b1;
         @(negedge clk);
         rd_pop = 1'b0;
      end
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      chk(ep_full == exp_full_after, {req, " full after release"}, ep_full, exp_full_after);
   endtask

   task automatic t_reset();
      chk(ep_full == 1'b0, "R1 full", ep_full, 0);
      chk(ep_irq == 1'b0, "R1 irq", ep_irq, 0);
      chk(hs_valid == 1'b0, "R1 hs", hs_valid, 0);
   endtask

   task automatic t_single();
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      chk(ep_full == 1'b0, "R10 ignored release", ep_full, 0);
      send(10, 8'h11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 R3 R1");
      readout(10, 8'h11, 1'b0, "R6 R10 R8");
   endtask

   task automatic t_two_nak();
      send(64, 8'h40, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2 max");
      send(5, 8'h90, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
      send(7, 8'hE0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
      readout(64, 8'h40, 1'b1, "R6 R8 R5");
      readout(5, 8'h90, 1'b0, "R7 R8");
   endtask

   task automatic t_drop();
      send(9, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 bad");
      send(65, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 long");
      send(3, 8'h55, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9 next");
      readout(3, 8'h55, 1'b0, "R9 readback");
   endtask

   task automatic t_same_cycle();
      send(4, 8'h70, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R11 first");
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      send(6, 8'hA0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R11 overlap");
      readout(6, 8'hA0, 1'b0, "R11 second");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_two_nak();
      t_drop();
      t_same_cycle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule